// File: doc/BRIEF.md
# Calendar Alarm Comparator

This block watches the current calendar time, delivered as six BCD fields (seconds, minutes, hours, day of week, day of month, month), and raises an alarm when that time agrees with a programmed alarm setting. Each of the six alarm registers holds a BCD value and a compare-enable bit. Only fields whose enable bit is set take part in the comparison, so software can match on any subset of fields. Examples are "every minute at second 30" or "every Monday at 07:00".

The comparison is made once per seconds update. The time keeper pulses `sec_tick` in the cycle where the presented time is the new time. When the enabled fields all agree and at least one field is enabled, a sticky alarm flag is set. The flag is set whether or not the interrupt is enabled. The interrupt output is the flag gated by an interrupt-enable bit. Software clears the flag by writing 0 to its bit in the control register. The usual sequence is to clear the flag and the interrupt enable together, load new alarm values, then re-enable the interrupt.

Register access uses a single-cycle write port and a combinational read port. Alarm registers sit at addresses 0 to 5 and the control register at address 6.

Top module: `cal_alarm_match`

## Requirements
- R1: After reset, all six alarm registers read 0x00, the control register reads 0x00 and `alarm_irq` is 0.
- R2: A write to address 0..5 (0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day of month, 5 month) stores all 8 bits, and a read of the same address returns them.
- R3: An alarm register whose bit 7 is 0 does not affect the match: a mismatch in that field does not stop the flag from setting. Writing 0x00 disables the field.
- R4: For an alarm register with bit 7 set, bits 6:0 must equal the 7-bit time input of that field, or the flag does not set.
- R5: The flag (control bit 0) becomes 1 only at a clock edge where `sec_tick` is 1 and the match condition holds. A matching time without `sec_tick` does not set it.
- R6: When all six alarm registers have bit 7 clear, the flag never sets.
- R7: Once set, the flag stays 1 through later ticks with a non-matching time until it is cleared. It sets whether or not interrupt enable (control bit 3) is 1.
- R8: `alarm_irq` is 1 exactly when both the flag (control bit 0) and the interrupt enable (control bit 3) are 1.
- R9: A write to address 6 loads bit 3 into the interrupt enable. If bit 0 of the written value is 0, the flag clears. If bit 0 is 1, the flag keeps its old value, so writing 1 never sets it. Other bits read back as 0.
- R10: When a clearing write to the control register and a matching tick fall in the same cycle, the flag is 1 afterwards.
- R11: The month field compares in the 1..12 BCD encoding, so an alarm value 0x92 matches month input 0x12 and does not match 0x11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (0..5 alarm, 6 control) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data, combinational |
| sec_tick | input | 1 | Seconds-update strobe from the time keeper |
| now_sec | input | 7 | Current seconds, BCD |
| now_min | input | 7 | Current minutes, BCD |
| now_hour | input | 7 | Current hours, BCD |
| now_wday | input | 7 | Current day of week |
| now_mday | input | 7 | Current day of month, BCD |
| now_mon | input | 7 | Current month, BCD 1..12 |
| alarm_irq | output | 1 | Alarm interrupt (flag AND enable) |

## Verification
The bench checks each of the following corner cases.

- **All fields disabled.** The bench ticks with every field disabled. A design that treated "no fields enabled" as a vacuous match would raise the flag on every second.
- **Clear and match in the same cycle.** The bench issues a clearing control write and a matching tick in the same cycle. A design that gave the write priority would lose that alarm.
- **Enable masking.** Bit 7 of each field is tested both ways: a disabled field with a deliberately wrong value must not block the match, and an enabled field that differs must block it. A design comparing all 8 bits, or ignoring the enable, fails one of these.
- **Flag behaviour.** The bench checks that the flag is sticky, that it sets while the interrupt is disabled, and that writing 1 to the flag bit does not set it.
- **Month boundary.** The month is tested at 12 against 11.

// File: rtl/cal_alarm_pkg.sv
`timescale 1ns/1ps
package cal_alarm_pkg;
  localparam int unsigned NUM_FIELDS = 6;
  localparam int unsigned FIELD_W    = 8;
  localparam int unsigned VAL_W      = FIELD_W - 1;
  localparam int unsigned ADDR_W     = 3;
  localparam int unsigned CTRL_ADDR  = 6;
  localparam int unsigned FLAG_BIT   = 0;
  localparam int unsigned IE_BIT     = 3;

  typedef logic [FIELD_W-1:0] alarm_reg_t;
  typedef logic [VAL_W-1:0]   time_val_t;

  // a field takes part only when its top bit is set
  function automatic logic field_enabled(alarm_reg_t areg);
    return areg[FIELD_W-1];
  endfunction

  // a disabled field always agrees; an enabled one needs equal value bits
  function automatic logic field_agrees(alarm_reg_t areg, time_val_t now);
    return !field_enabled(areg) || (areg[VAL_W-1:0] == now);
  endfunction

  function automatic alarm_reg_t pack_ctrl(logic flag, logic ie);
    alarm_reg_t r;
    r = '0;
    r[FLAG_BIT] = flag;
    r[IE_BIT]   = ie;
    return r;
  endfunction
endpackage

// File: rtl/alarm_field_slot.sv
`timescale 1ns/1ps
module alarm_field_slot
  import cal_alarm_pkg::*;
#(
  parameter int unsigned SLOT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  alarm_reg_t        wr_data,
  input  time_val_t         now,
  output alarm_reg_t        value,
  output logic              enabled,
  output logic              agrees
);
  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(SLOT);

  logic       sel_wr;
  alarm_reg_t val_q;

  assign sel_wr = wr_en && (wr_addr == MY_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n)      val_q <= '0;
    else if (sel_wr) val_q <= wr_data;
  end

  assign value   = val_q;
  assign enabled = field_enabled(val_q);
  assign agrees  = field_agrees(val_q, now);

  // R2: a write lands in this slot on the next cycle
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr |=> (value == $past(wr_data)));
  // R3: a disabled slot never blocks the match
  a_r3_disabled_agrees: assert property (@(posedge clk) disable iff (!rst_n)
    !value[FIELD_W-1] |-> agrees);
endmodule

// File: rtl/alarm_match_tree.sv
`timescale 1ns/1ps
module alarm_match_tree
  import cal_alarm_pkg::*;
#(
  parameter int unsigned N = NUM_FIELDS
) (
  input  logic [N-1:0] en_vec,
  input  logic [N-1:0] agree_vec,
  output logic         any_enabled,
  output logic         all_agree,
  output logic         match
);
  assign any_enabled = |en_vec;
  assign all_agree   = &agree_vec;
  assign match       = any_enabled && all_agree;
endmodule

// File: rtl/alarm_flag_ctrl.sv
`timescale 1ns/1ps
module alarm_flag_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_tick,
  input  logic match,
  input  logic ctrl_wr,
  input  logic wr_flag_bit,
  input  logic wr_ie_bit,
  output logic flag_q,
  output logic ie_q,
  output logic irq
);
  logic set_ev;
  logic clr_ev;

  assign set_ev = sec_tick && match;
  assign clr_ev = ctrl_wr && !wr_flag_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      ie_q   <= 1'b0;
    end else begin
      if (set_ev)      flag_q <= 1'b1;
      else if (clr_ev) flag_q <= 1'b0;
      if (ctrl_wr)     ie_q   <= wr_ie_bit;
    end
  end

  assign irq = flag_q && ie_q;

  // R5: the flag only rises after a matching tick
  a_r5_rise_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(sec_tick && match));
  // R7: sticky until a clearing write
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_ev) |=> flag_q);
  // R9: a clearing write without a match drops the flag
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ev && !set_ev) |=> !flag_q);
  // R10: a match in the clearing cycle wins
  a_r10_match_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> flag_q);
endmodule

// File: rtl/cal_alarm_match.sv
`timescale 1ns/1ps
module cal_alarm_match
  import cal_alarm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [7:0]  wr_data,
  input  logic [2:0]  rd_addr,
  output logic [7:0]  rd_data,
  input  logic        sec_tick,
  input  logic [6:0]  now_sec,
  input  logic [6:0]  now_min,
  input  logic [6:0]  now_hour,
  input  logic [6:0]  now_wday,
  input  logic [6:0]  now_mday,
  input  logic [6:0]  now_mon,
  output logic        alarm_irq
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

  time_val_t           now_arr   [NUM_FIELDS];
  alarm_reg_t          slot_val  [NUM_FIELDS];
  logic [NUM_FIELDS-1:0] en_vec;
  logic [NUM_FIELDS-1:0] agree_vec;
  logic any_enabled, all_agree, match;
  logic ctrl_wr, flag_q, ie_q;

  assign now_arr[0] = now_sec;
  assign now_arr[1] = now_min;
  assign now_arr[2] = now_hour;
  assign now_arr[3] = now_wday;
  assign now_arr[4] = now_mday;
  assign now_arr[5] = now_mon;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_slot
    alarm_field_slot #(.SLOT(g)) i_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .now     (now_arr[g]),
      .value   (slot_val[g]),
      .enabled (en_vec[g]),
      .agrees  (agree_vec[g])
    );
  end

  alarm_match_tree #(.N(NUM_FIELDS)) i_tree (
    .en_vec      (en_vec),
    .agree_vec   (agree_vec),
    .any_enabled (any_enabled),
    .all_agree   (all_agree),
    .match       (match)
  );

  assign ctrl_wr = wr_en && (wr_addr == CTRL_A);

  alarm_flag_ctrl i_flag (
    .clk         (clk),
    .rst_n       (rst_n),
    .sec_tick    (sec_tick),
    .match       (match),
    .ctrl_wr     (ctrl_wr),
    .wr_flag_bit (wr_data[FLAG_BIT]),
    .wr_ie_bit   (wr_data[IE_BIT]),
    .flag_q      (flag_q),
    .ie_q        (ie_q),
    .irq         (alarm_irq)
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr == CTRL_A) rd_data = pack_ctrl(flag_q, ie_q);
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (rd_addr == ADDR_W'(i)) rd_data = slot_val[i];
    end
  end

  // R6: with no field enabled a clear flag stays clear
  a_r6_none_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_enabled && !flag_q) |=> !flag_q);
  // R8: the interrupt never shows without the flag
  a_r8_irq_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq |-> flag_q);
  // R4: any disagreeing enabled field blocks the match
  a_r4_block: assert property (@(posedge clk) disable iff (!rst_n)
    !all_agree |-> !match);
endmodule

// File: tb/test_cal_alarm_match.sv
`timescale 1ns/1ps
module test_cal_alarm_match;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic sec_tick = 1'b0;
  logic [6:0] now_sec = '0, now_min = '0, now_hour = '0;
  logic [6:0] now_wday = '0, now_mday = '0, now_mon = '0;
  logic alarm_irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cal_alarm_match i_cal_alarm_match (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .sec_tick(sec_tick), .now_sec(now_sec), .now_min(now_min),
    .now_hour(now_hour), .now_wday(now_wday), .now_mday(now_mday),
    .now_mon(now_mon), .alarm_irq(alarm_irq)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input int exp);
    rd_addr = a;
    #1;
    check(req, rd_data, exp);
  endtask

  task automatic set_time(input logic [6:0] s, m, h, w, d, mo);
    now_sec = s; now_min = m; now_hour = h;
    now_wday = w; now_mday = d; now_mon = mo;
  endtask

  task automatic tick();
    sec_tick = 1'b1;
    cyc();
    sec_tick = 1'b0;
  endtask

  task automatic clear_all();
    wr(3'd6, 8'h00);
    for (int i = 0; i < 6; i++) wr(3'(i), 8'h00);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 6; i++) rd_chk("R1 alarm reg reset", 3'(i), 0);
    rd_chk("R1 ctrl reset", 3'd6, 0);
    check("R1 irq reset", alarm_irq, 0);
  endtask

  task automatic t_readback();
    for (int i = 0; i < 6; i++) wr(3'(i), 8'(8'hA1 + 8'(i * 7)));
    for (int i = 0; i < 6; i++) rd_chk("R2 readback", 3'(i), 8'hA1 + i * 7);
    clear_all();
  endtask

  task automatic t_all_disabled();
    wr(3'd0, 8'h30);
    set_time(7'h30, 7'h00, 7'h00, 7'h00, 7'h01, 7'h01);
    tick();
    rd_chk("R6 all disabled no flag", 3'd6, 0);
    set_time(7'h00, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00);
    wr(3'd0, 8'h00);
    tick();
    rd_chk("R6 zero time no flag", 3'd6, 0);
  endtask

  task automatic t_single_field();
    wr(3'd0, 8'hB0);
    wr(3'd1, 8'h45);
    set_time(7'h30, 7'h12, 7'h08, 7'h02, 7'h15, 7'h06);
    cyc();
    rd_chk("R5 no tick no flag", 3'd6, 0);
    tick();
    rd_chk("R3 disabled min ignored, flag set", 3'd6, 8'h01);
    check("R7 flag sets with ie off, irq low", alarm_irq, 0);
    set_time(7'h31, 7'h12, 7'h08, 7'h02, 7'h15, 7'h06);
    tick();
    rd_chk("R7 sticky", 3'd6, 8'h01);
    wr(3'd6, 8'h01);
    rd_chk("R9 write 1 keeps flag", 3'd6, 8'h01);
    wr(3'd6, 8'hF6);
    rd_chk("R9 write 0 clears, ie loads, others 0", 3'd6, 8'h00);
    wr(3'd6, 8'h01);
    rd_chk("R9 write 1 does not set", 3'd6, 8'h00);
    clear_all();
  endtask

  task automatic t_mismatch();
    wr(3'd0, 8'hB0);
    wr(3'd1, 8'h85);
    set_time(7'h30, 7'h06, 7'h00, 7'h00, 7'h01, 7'h01);
    tick();
    rd_chk("R4 enabled min mismatch blocks", 3'd6, 0);
    set_time(7'h30, 7'h05, 7'h00, 7'h00, 7'h01, 7'h01);
    tick();
    rd_chk("R4 both enabled agree", 3'd6, 8'h01);
    clear_all();
  endtask

  task automatic t_irq();
    wr(3'd6, 8'h08);
    check("R8 irq low with ie only", alarm_irq, 0);
    wr(3'd2, 8'h87);
    set_time(7'h00, 7'h00, 7'h07, 7'h00, 7'h01, 7'h01);
    tick();
    rd_chk("R8 ctrl flag+ie", 3'd6, 8'h09);
    check("R8 irq high", alarm_irq, 1);
    wr(3'd6, 8'h00);
    check("R8 irq low after ie off", alarm_irq, 0);
    clear_all();
  endtask

  task automatic t_month();
    wr(3'd0, 8'h80); wr(3'd1, 8'h80); wr(3'd2, 8'h80);
    wr(3'd3, 8'h85); wr(3'd4, 8'hB1); wr(3'd5, 8'h92);
    set_time(7'h00, 7'h00, 7'h00, 7'h05, 7'h31, 7'h11);
    tick();
    rd_chk("R11 month 11 no match", 3'd6, 0);
    set_time(7'h00, 7'h00, 7'h00, 7'h05, 7'h31, 7'h12);
    tick();
    rd_chk("R11 month 12 match", 3'd6, 8'h01);
    clear_all();
  endtask

  task automatic t_race();
    wr(3'd0, 8'hD9);
    set_time(7'h59, 7'h00, 7'h00, 7'h00, 7'h01, 7'h01);
    tick();
    rd_chk("R10 setup flag", 3'd6, 8'h01);
    wr_en = 1'b1; wr_addr = 3'd6; wr_data = 8'h00; sec_tick = 1'b1;
    cyc();
    wr_en = 1'b0; sec_tick = 1'b0;
    rd_chk("R10 match wins over clear", 3'd6, 8'h01);
    clear_all();
    rd_chk("R9 cleared after race", 3'd6, 0);
  endtask

  initial begin
    #1600000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_all_disabled();
    t_single_field();
    t_mismatch();
    t_irq();
    t_month();
    t_race();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule